// File: doc/BRIEF.md
# Memory-Card Slot Status Register Block

This block is a small word-addressed register file that sits beside a board's memory-card slot. Software can read an identification word, a fixed address-decode word and a flash-programming word that always reads zero. The slot status word combines two bits. One is the live write-protect level of the card. The other is a sticky card-insertion flag. The block does not model the card host controller, and it does not program flash.

The slot drives the two slot inputs asynchronously. Each passes through a synchroniser before the block uses it. When the synchronised card-present input is high, the insertion flag is set. The flag stays set after the card-present input falls. While set, the flag drives an interrupt output. Software acknowledges the interrupt by writing the status word with the card bit at one. If the card-present input is still high in the cycle of that write, the flag stays set.

Reads are combinational from the word address. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `slot_status_regs`

## Requirements
- R1: Word address 0 reads the identification constant 0x41034003.
- R2: Word address 3 reads the decode constant 0x00000011.
- R3: Word address 1 reads zero. Writes to word addresses 0, 1 and 3 change nothing that any read or `card_irq` shows.
- R4: Bit 0 of the status word (word address 2) follows `wp_in`, both rising and falling. A change on `wp_in` first shows in this bit after the second rising clock edge following the change.
- R5: Bit 3 of the status word is the card-insertion flag. It sets after the third rising edge following a rise of `card_in`, and it stays set after `card_in` falls.
- R6: A write to word address 2 with bit 3 at one clears the insertion flag. A write to word address 2 with bit 3 at zero leaves the flag unchanged, whatever the other data bits are.
- R7: `card_irq` equals bit 3 of the status word at all times.
- R8: If the synchronised card input is high at the edge of a clearing write, the flag stays set.
- R9: After reset, the status word reads zero and `card_irq` is low. Status bits 1, 2 and 4 to 31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wp_in | input | 1 | Asynchronous write-protect level from the slot |
| card_in | input | 1 | Asynchronous card-present level from the slot |
| card_irq | output | 1 | Card-insertion interrupt, high while the flag is set |

## Verification
The only state inside the block is the two synchroniser chains and the insertion flag. A fault in any of them shows at the ports within a few cycles. A flag that drops by itself, or ignores a clear, appears on `card_irq` at the next clock edge and also in bit 3 of the status read. A wrong synchroniser depth moves the first changed read of bit 0 or bit 3 by one edge. The bench therefore samples the cycles immediately before and after each expected change.

// File: rtl/slot_status_pkg.sv
package slot_status_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [DATA_W-1:0] ID_WORD     = 32'h4103_4003;
    localparam logic [DATA_W-1:0] DECODE_WORD = 32'h0000_0011;

    localparam int WP_BIT   = 0;
    localparam int CARD_BIT = 3;

    typedef enum logic [ADDR_W-1:0] {
        SLOT_ID    = 2'd0,
        SLOT_FLASH = 2'd1,
        SLOT_STAT  = 2'd2,
        SLOT_DEC   = 2'd3
    } slot_reg_e;

    typedef struct packed {
        logic wp;
        logic card;
    } slot_in_t;

    function automatic logic [DATA_W-1:0] pack_status(logic wp, logic card);
        logic [DATA_W-1:0] r;
        r           = '0;
        r[WP_BIT]   = wp;
        r[CARD_BIT] = card;
        return r;
    endfunction

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/slot_latch.sv
module slot_latch (
    input  logic clk,
    input  logic rst,
    input  logic card_sync,
    input  logic clr_req,
    output logic card_flag
);
    always_ff @(posedge clk) begin
        if (rst) card_flag <= 1'b0;
        else     card_flag <= card_sync | (card_flag & ~clr_req);
    end

    // R5: flag is sticky without a clear
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (card_flag && !clr_req) |=> card_flag);

    // R8: a high synchronised input always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        card_sync |=> card_flag);

    // R6: a clear with no pending set drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !card_sync) |=> !card_flag);
endmodule

// File: rtl/slot_regdec.sv
module slot_regdec
    import slot_status_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_sync,
    input  logic              card_flag,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        case (slot_reg_e'(addr))
            SLOT_ID:    rdata = ID_WORD;
            SLOT_FLASH: rdata = '0;
            SLOT_STAT:  rdata = pack_status(wp_sync, card_flag);
            SLOT_DEC:   rdata = DECODE_WORD;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
    import slot_status_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wp_in,
    input  logic              card_in,
    output logic              card_irq
);
    localparam int IN_W = $bits(slot_in_t);

    slot_in_t raw_in, sync_in;
    logic     clr_req;
    logic     card_flag;
    logic     unused_wdata;

    assign raw_in.wp   = wp_in;
    assign raw_in.card = card_in;

    slot_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_in),
        .sync_out (sync_in)
    );

    assign clr_req = bus_wr && (slot_reg_e'(bus_addr) == SLOT_STAT)
                     && bus_wdata[CARD_BIT];
    assign unused_wdata = ^{bus_wdata[DATA_W-1:CARD_BIT+1], bus_wdata[CARD_BIT-1:0]};

    slot_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .card_sync (sync_in.card),
        .clr_req   (clr_req),
        .card_flag (card_flag)
    );

    slot_regdec u_dec (
        .addr      (bus_addr),
        .wp_sync   (sync_in.wp),
        .card_flag (card_flag),
        .rdata     (bus_rdata)
    );

    assign card_irq = card_flag;

    // R7: interrupt output matches status bit 3 whenever it is read
    a_r7_irq_matches: assert property (@(posedge clk) disable iff (rst)
        (slot_reg_e'(bus_addr) == SLOT_STAT) |-> (bus_rdata[CARD_BIT] == card_irq));

    // R9: spare status bits read zero
    a_r9_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (slot_reg_e'(bus_addr) == SLOT_STAT) |->
        (bus_rdata[DATA_W-1:CARD_BIT+1] == '0 && bus_rdata[CARD_BIT-1:WP_BIT+1] == '0));

    // R1: identification word never changes
    a_r1_id_const: assert property (@(posedge clk) disable iff (rst)
        (slot_reg_e'(bus_addr) == SLOT_ID) |-> (bus_rdata == 32'h4103_4003));
endmodule

// File: tb/slot_status_regs_bench.sv
module slot_status_regs_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wp_in;
    logic        card_in;
    logic        card_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    slot_status_regs u_slot_status_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wp_in     (wp_in),
        .card_in   (card_in),
        .card_irq  (card_irq)
    );

    typedef struct packed {
        logic        wp;
        logic        card;
        logic        do_wr;
        logic [1:0]  wa;
        logic [31:0] wd;
        logic [1:0]  ra;
        logic [31:0] er;
        logic        ei;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 14;
    localparam row_t VEC [NROWS] = '{
        '{1'b0,1'b0,1'b0,2'd0,32'h0,       2'd0,32'h4103_4003,1'b0,4'd1}, // R1
        '{1'b0,1'b0,1'b0,2'd0,32'h0,       2'd3,32'h0000_0011,1'b0,4'd2}, // R2
        '{1'b0,1'b0,1'b0,2'd0,32'h0,       2'd1,32'h0,        1'b0,4'd3}, // R3
        '{1'b0,1'b0,1'b0,2'd0,32'h0,       2'd2,32'h0,        1'b0,4'd9}, // R9
        '{1'b1,1'b0,1'b0,2'd0,32'h0,       2'd2,32'h1,        1'b0,4'd4}, // R4
        '{1'b0,1'b1,1'b0,2'd0,32'h0,       2'd2,32'h8,        1'b1,4'd5}, // R5
        '{1'b0,1'b0,1'b0,2'd0,32'h0,       2'd2,32'h8,        1'b1,4'd5}, // R5 sticky
        '{1'b0,1'b0,1'b1,2'd2,32'hFFFF_FFF7,2'd2,32'h8,       1'b1,4'd6}, // R6 bit3 zero
        '{1'b1,1'b0,1'b1,2'd1,32'hFFFF_FFFF,2'd1,32'h0,       1'b1,4'd3}, // R3
        '{1'b1,1'b0,1'b1,2'd3,32'hFFFF_FFFF,2'd3,32'h11,      1'b1,4'd3}, // R3
        '{1'b1,1'b0,1'b1,2'd0,32'h0,       2'd2,32'h9,        1'b1,4'd3}, // R3
        '{1'b1,1'b0,1'b1,2'd2,32'h8,       2'd2,32'h1,        1'b0,4'd6}, // R6
        '{1'b0,1'b1,1'b1,2'd2,32'h8,       2'd2,32'h8,        1'b1,4'd8}, // R8
        '{1'b0,1'b0,1'b1,2'd2,32'hFFFF_FFFF,2'd2,32'h0,       1'b0,4'd7}  // R7 and R6
    };

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = 2'd2; bus_wr = 1'b0; bus_wdata = '0;
        wp_in = 1'b0; card_in = 1'b0;
        step(3);
        rst = 1'b0;
        // R9: reset state
        check32("R9 reset status", bus_rdata, 32'h0);
        check32("R9 reset irq", {31'b0, card_irq}, 32'h0);

        for (int k = 0; k < NROWS; k++) begin
            wp_in   = VEC[k].wp;
            card_in = VEC[k].card;
            step(4);
            if (VEC[k].do_wr) begin
                bus_addr  = VEC[k].wa;
                bus_wdata = VEC[k].wd;
                bus_wr    = 1'b1;
                step(1);
                bus_wr = 1'b0;
            end
            bus_addr = VEC[k].ra;
            #1;
            check32($sformatf("R%0d row %0d rdata", VEC[k].req, k), bus_rdata, VEC[k].er);
            check32($sformatf("R%0d row %0d irq", VEC[k].req, k), {31'b0, card_irq}, {31'b0, VEC[k].ei});
        end

        // R4: synchroniser latency on write-protect, rising then falling
        bus_addr = 2'd2;
        wp_in = 1'b1;
        step(1);
        check32("R4 wp one edge", {31'b0, bus_rdata[0]}, 32'h0);
        step(1);
        check32("R4 wp two edges", {31'b0, bus_rdata[0]}, 32'h1);
        wp_in = 1'b0;
        step(1);
        check32("R4 wp fall one edge", {31'b0, bus_rdata[0]}, 32'h1);
        step(1);
        check32("R4 wp fall two edges", {31'b0, bus_rdata[0]}, 32'h0);

        // R5 and R7: card flag latency
        card_in = 1'b1;
        step(2);
        check32("R5 card two edges", {31'b0, card_irq}, 32'h0);
        step(1);
        check32("R5 card three edges", {31'b0, card_irq}, 32'h1);
        check32("R7 irq vs bit3", {31'b0, bus_rdata[3]}, {31'b0, card_irq});
        card_in = 1'b0;
        step(5);
        check32("R5 card held after fall", bus_rdata, 32'h8);

        // R9: reset clears a set flag
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        check32("R9 reset clears flag", bus_rdata, 32'h0);
        check32("R9 reset clears irq", {31'b0, card_irq}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule